// File: doc/BRIEF.md
# PLL Clock Control with Lock-Loss Gating

This block sits between an external phase-locked loop and the chip's system clock tree. Software sees two 32-bit registers. One holds the PLL feedback multiplication factor, which is driven straight to the PLL, and a sticky flag that records any loss of lock. The other holds a 3-bit code that divides the fast input clock by a power of two. The block turns that code into a single-cycle clock-enable pulse, `clk_en`, which the clock tree uses to qualify its registers.

Whenever lock is missing, `clk_en` is held low. Lock counts as missing when the PLL reports it, and also for a fixed settling window after software changes the multiplication factor. Changing the divide code never gates the enable. A new code is adopted only when the current divided period ends, so no short period appears.

There are two resets. Power-on reset clears everything. Hard reset clears the divider and the multiplication factor but leaves the sticky lock flag alone, so software can still see after a hard reset that lock was lost.

Top module: `pllclk_ctrl`

## Requirements
- R1: With active divide code c (0 to 6), `clk_en` pulses once every 2^c clock cycles while lock is held. The code is held in bits [2:0] of the divider register (`reg_sel`=0), and code 0 means every cycle.
- R2: A write to the divider register never drops `clk_en` for lock reasons and never sets the sticky lock flag.
- R3: A new divide code takes effect only when the current divided period completes, so the active code changes only in a cycle that carries a `clk_en` tick.
- R4: A write of the reserved divide code 3'b111 is ignored, and the previously programmed code remains readable and active.
- R5: A control-register write whose bits [11:0] differ from the stored multiplication factor holds `clk_en` low for the 8 cycles after the write. After that, `clk_en` stays low until `pll_locked` is high. Writing the stored value again has no effect.
- R6: In any cycle that follows a cycle with `pll_locked` low, `clk_en` is low.
- R7: Control-register bit 16 is a sticky lock flag. It is set by any lock loss, including the settling window of R5. Writing 1 to bit 16 clears it and writing 0 leaves it unchanged. A lock loss in the same cycle as a clear keeps it set.
- R8: Power-on reset (`por_n` low) clears both registers and the sticky flag. Hard reset (`hrst_n` low) clears the divide code and the multiplication factor but keeps the sticky flag. `clk_en` is low during either reset.
- R9: The control register reads the multiplication factor in bits [11:0] and the sticky flag in bit 16. The divider register reads the code in bits [2:0]. All other bits read zero and ignore written data. `pll_mf` always equals the stored multiplication factor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock from the PLL |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hrst_n | input | 1 | Hard reset, active low, asynchronous; sticky flag is unaffected |
| reg_sel | input | 1 | Register select: 0 divider register, 1 control register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| pll_locked | input | 1 | Lock indication from the external PLL |
| pll_mf | output | 12 | Multiplication factor driven to the PLL feedback divider |
| clk_en | output | 1 | Divided system clock enable, gated while lock is lost |

## Verification
The assertions check on every cycle the properties that can be stated locally. An unlocked PLL always silences `clk_en` on the next cycle. A changed multiplication factor always raises the internal loss state. A lock loss always leaves the sticky flag set. The active divide code never moves in the middle of a period. A reserved-code write never alters the stored code, and a hard reset never clears the sticky flag.

Only the bench scenarios can show the rest. These are the exact divide ratios measured over whole windows, the length of the 8-cycle settling gap before a relock, and that divider writes leave both gating and the flag untouched. They also cover the write-one-to-clear ordering against a simultaneous loss and the different reach of the two resets. All of this is compared against a cycle-level reference model during a long random run.

// File: rtl/pllclk_pkg.sv
`timescale 1ns/1ps
package pllclk_pkg;
    localparam int  REG_W    = 32;
    localparam logic SEL_DIV  = 1'b0;
    localparam logic SEL_CTRL = 1'b1;
endpackage

// File: rtl/pllclk_regs.sv
`timescale 1ns/1ps
module pllclk_regs
    import pllclk_pkg::*;
#(
    parameter int MF_W       = 12,
    parameter int DIV_W      = 3,
    parameter int STICKY_BIT = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_all_n,
    input  logic             hrst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             lost_now,
    output logic             mf_change,
    output logic [MF_W-1:0]  mf_o,
    output logic [DIV_W-1:0] code_o
);
    localparam logic [DIV_W-1:0] CODE_RSVD = '1;

    typedef struct packed {
        logic [MF_W-1:0]  mf;
        logic [DIV_W-1:0] code;
    } regs_t;

    regs_t r_d, r_q;
    logic  sticky_d, sticky_q;
    logic  wr_div, wr_ctl;
    logic  unused_wdata;

    assign unused_wdata = ^reg_wdata;

    // writes are only honoured outside every reset
    assign wr_div    = reg_wr && rst_all_n && (reg_sel == SEL_DIV);
    assign wr_ctl    = reg_wr && rst_all_n && (reg_sel == SEL_CTRL);
    assign mf_change = wr_ctl && (reg_wdata[MF_W-1:0] != r_q.mf);

    always_comb begin
        r_d = r_q;
        if (wr_div && (reg_wdata[DIV_W-1:0] != CODE_RSVD)) begin
            r_d.code = reg_wdata[DIV_W-1:0];
        end
        if (wr_ctl) begin
            r_d.mf = reg_wdata[MF_W-1:0];
        end
        // a loss in this cycle overrides a clear request
        sticky_d = lost_now || (sticky_q && !(wr_ctl && reg_wdata[STICKY_BIT]));
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // sticky flag lives in the power-on domain only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sticky_q <= 1'b0;
        end else begin
            sticky_q <= sticky_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_CTRL) begin
            reg_rdata[MF_W-1:0]   = r_q.mf;
            reg_rdata[STICKY_BIT] = sticky_q;
        end else begin
            reg_rdata[DIV_W-1:0]  = r_q.code;
        end
    end

    assign mf_o   = r_q.mf;
    assign code_o = r_q.code;

    assert_rsvd_ignored_R4: assert property (@(posedge clk) disable iff (!rst_all_n)
        (wr_div && (reg_wdata[DIV_W-1:0] == CODE_RSVD)) |=> $stable(r_q.code));

    assert_sticky_set_R7: assert property (@(posedge clk) disable iff (!por_n)
        lost_now |=> sticky_q);

    assert_sticky_hrst_R8: assert property (@(posedge clk) disable iff (!por_n)
        (!hrst_n && sticky_q) |=> sticky_q);
endmodule

// File: rtl/pllclk_lock.sv
`timescale 1ns/1ps
module pllclk_lock #(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_all_n,
    input  logic mf_change,
    input  logic pll_locked,
    output logic lost_now,
    output logic lost_q
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic              lost;
    } lock_t;

    lock_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mf_change) begin
            s_d.hold = HOLD_W'(HOLD_CYC);
        end else if (s_q.hold != '0) begin
            s_d.hold = s_q.hold - 1'b1;
        end
        s_d.lost = (s_d.hold != '0) || !pll_locked;
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            s_q.hold <= '0;
            s_q.lost <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign lost_now = s_d.lost;
    assign lost_q   = s_q.lost;

    assert_mf_forces_loss_R5: assert property (@(posedge clk) disable iff (!rst_all_n)
        mf_change |=> lost_q);

    assert_unlock_loss_R6: assert property (@(posedge clk) disable iff (!rst_all_n)
        !pll_locked |=> lost_q);
endmodule

// File: rtl/pllclk_div.sv
`timescale 1ns/1ps
module pllclk_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_all_n,
    input  logic [DIV_W-1:0] code,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 2;

    typedef struct packed {
        logic [DIV_W-1:0] act;
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t             s_d, s_q;
    logic [CNT_W-1:0] last;

    // terminal count is 2^act - 1: the low act bits set
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            last[i] = (i < int'(s_q.act));
        end
    end

    assign tick = (s_q.cnt == last);

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.cnt = '0;
            s_d.act = code;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assert_switch_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_all_n)
        !tick |=> $stable(s_q.act));
endmodule

// File: rtl/pllclk_ctrl.sv
`timescale 1ns/1ps
module pllclk_ctrl
    import pllclk_pkg::*;
#(
    parameter int MF_W       = 12,
    parameter int DIV_W      = 3,
    parameter int STICKY_BIT = 16,
    parameter int HOLD_CYC   = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             hrst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             pll_locked,
    output logic [MF_W-1:0]  pll_mf,
    output logic             clk_en
);
    logic             rst_all_n;
    logic             lost_now, lost_q, mf_change, tick;
    logic [DIV_W-1:0] code;

    assign rst_all_n = por_n & hrst_n;

    pllclk_regs #(
        .MF_W(MF_W), .DIV_W(DIV_W), .STICKY_BIT(STICKY_BIT)
    ) regs_i (
        .clk(clk), .por_n(por_n), .rst_all_n(rst_all_n), .hrst_n(hrst_n),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .lost_now(lost_now), .mf_change(mf_change),
        .mf_o(pll_mf), .code_o(code)
    );

    pllclk_lock #(
        .HOLD_CYC(HOLD_CYC)
    ) lock_i (
        .clk(clk), .rst_all_n(rst_all_n), .mf_change(mf_change),
        .pll_locked(pll_locked), .lost_now(lost_now), .lost_q(lost_q)
    );

    pllclk_div #(
        .DIV_W(DIV_W)
    ) div_i (
        .clk(clk), .rst_all_n(rst_all_n), .code(code), .tick(tick)
    );

    assign clk_en = tick && !lost_q;

    assert_unlock_gates_en_R6: assert property (@(posedge clk) disable iff (!rst_all_n)
        !pll_locked |=> !clk_en);
endmodule

// File: tb/pllclk_ctrl_tb_top.sv
`timescale 1ns/1ps
module pllclk_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, hrst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pll_locked = 1'b1;
    logic [11:0] pll_mf;
    logic        clk_en;

    int n_chk = 0, n_fail = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pllclk_ctrl dut_i (
        .clk(clk), .por_n(por_n), .hrst_n(hrst_n), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pll_locked(pll_locked), .pll_mf(pll_mf), .clk_en(clk_en)
    );

    // reference model built from the requirements
    logic [2:0]  m_code = '0, m_act = '0;
    logic [5:0]  m_cnt = '0;
    logic [11:0] m_mf = '0;
    int          m_hold = 0;
    logic        m_lost = 1'b1, m_sticky = 1'b0;

    function automatic logic [5:0] last_of(input logic [2:0] c);
        return 6'((1 << c) - 1);
    endfunction

    function automatic logic exp_en();
        return (m_cnt == last_of(m_act)) && !m_lost;
    endfunction

    function automatic logic [31:0] exp_rd(input logic sel);
        if (sel) return {15'b0, m_sticky, 4'b0, m_mf};
        return {29'b0, m_code};
    endfunction

    always @(posedge clk) begin
        logic wctl, wdiv, chg, ld;
        int   hd;
        if (!por_n) begin
            m_code <= '0; m_act <= '0; m_cnt <= '0; m_mf <= '0;
            m_hold <= 0; m_lost <= 1'b1; m_sticky <= 1'b0;
        end else if (!hrst_n) begin
            m_code <= '0; m_act <= '0; m_cnt <= '0; m_mf <= '0;
            m_hold <= 0; m_lost <= 1'b1; m_sticky <= m_sticky | !pll_locked;
        end else begin
            wctl = reg_wr && reg_sel;
            wdiv = reg_wr && !reg_sel;
            chg  = wctl && (reg_wdata[11:0] != m_mf);
            hd   = chg ? 8 : (m_hold > 0 ? m_hold - 1 : 0);
            ld   = (hd != 0) || !pll_locked;
            m_hold   <= hd;
            m_lost   <= ld;
            m_sticky <= ld || (m_sticky && !(wctl && reg_wdata[16]));
            if (m_cnt == last_of(m_act)) begin
                m_cnt <= '0;
                m_act <= m_code;
            end else begin
                m_cnt <= m_cnt + 1'b1;
            end
            if (wdiv && reg_wdata[2:0] != 3'b111) m_code <= reg_wdata[2:0];
            if (wctl) m_mf <= reg_wdata[11:0];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            chk("R1 R3 R5 R6 clk_en vs model", {31'b0, clk_en}, {31'b0, exp_en()});
            chk("R9 pll_mf vs model", {20'b0, pll_mf}, {20'b0, m_mf});
            chk("R7 R8 R9 readback vs model", reg_rdata, exp_rd(reg_sel));
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic count_en(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (clk_en) c++;
        end
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int c;
        void'($urandom(32'h1DE5_7A11));

        // reset state, R8
        cyc(3);
        chk("R8 clk_en low in reset", {31'b0, clk_en}, 32'd0);
        rd(1'b0, d); chk("R8 divider reg after POR", d, 32'd0);
        rd(1'b1, d); chk("R8 control reg after POR", d, 32'd0);
        por_n = 1'b1; hrst_n = 1'b1;
        cyc(2);
        chk_on = 1'b1;

        // R1: divide by 1, 4 and 64
        count_en(16, c); chk("R1 code0 pulses in 16", c, 16);
        wr(1'b0, 32'd2); cyc(8);
        count_en(64, c); chk("R1 code2 pulses in 64", c, 16);
        wr(1'b0, 32'd6); cyc(8);
        count_en(128, c); chk("R1 code6 pulses in 128", c, 2);

        // R4: reserved code ignored
        wr(1'b0, 32'd7);
        rd(1'b0, d); chk("R4 reserved code ignored", d, 32'd6);
        cyc(70);
        count_en(128, c); chk("R4 old divide kept", c, 2);

        // R2: divider write does not gate nor set flag
        wr(1'b1, 32'h0001_0000);
        rd(1'b1, d); chk("R2 flag cleared before test", d, 32'd0);
        wr(1'b0, 32'd0); cyc(70);
        wr(1'b0, 32'd1); cyc(4);
        count_en(32, c); chk("R2 R1 code1 pulses in 32", c, 16);
        rd(1'b1, d); chk("R2 flag not set by divider writes", d, 32'd0);
        wr(1'b0, 32'd0); cyc(4);

        // R5: changed MF gives an 8 cycle gap, then relock
        wr(1'b1, 32'h0000_0005);
        chk("R5 gap cycle 1", {31'b0, clk_en}, 32'd0);
        for (int i = 2; i <= 8; i++) begin
            @(negedge clk);
            chk("R5 gap cycle", {31'b0, clk_en}, 32'd0);
        end
        @(negedge clk);
        chk("R5 enable back after 8", {31'b0, clk_en}, 32'd1);
        #1;
        rd(1'b1, d); chk("R7 flag set by MF change", d, 32'h0001_0005);
        // same value again: no gap
        wr(1'b1, 32'h0000_0005);
        count_en(8, c); chk("R5 rewrite same MF no gap", c, 8);
        // relock waits for pll_locked
        pll_locked = 1'b0;
        wr(1'b1, 32'h0000_0009);
        cyc(12);
        chk("R5 R6 held off while unlocked", {31'b0, clk_en}, 32'd0);
        pll_locked = 1'b1;
        cyc(2);
        chk("R5 enable after lock returns", {31'b0, clk_en}, 32'd1);

        // R7: write one clears, write zero keeps, loss wins over clear
        wr(1'b1, 32'h0001_0009);
        rd(1'b1, d); chk("R7 W1C clears", d, 32'h0000_0009);
        pll_locked = 1'b0; cyc(); pll_locked = 1'b1; cyc(2);
        wr(1'b1, 32'h0000_0009);
        rd(1'b1, d); chk("R7 write zero keeps flag", d, 32'h0001_0009);
        wr(1'b1, 32'h0001_0009);
        pll_locked = 1'b0;
        wr(1'b1, 32'h0001_0009);
        pll_locked = 1'b1; cyc();
        rd(1'b1, d); chk("R7 loss wins over clear", d, 32'h0001_0009);

        // R9: reserved bits read zero
        wr(1'b0, 32'hFFFF_FFF3);
        rd(1'b0, d); chk("R9 divider reserved bits", d, 32'd3);
        wr(1'b1, 32'hFFFE_F5A5);
        rd(1'b1, d); chk("R9 control reserved bits", d, 32'h0001_05A5);
        chk("R9 pll_mf output", {20'b0, pll_mf}, 32'h5A5);
        cyc(12);

        // R8: hard reset keeps flag, POR clears it
        hrst_n = 1'b0; cyc(2);
        chk("R8 clk_en low in hard reset", {31'b0, clk_en}, 32'd0);
        rd(1'b0, d); chk("R8 code cleared by hard reset", d, 32'd0);
        rd(1'b1, d); chk("R8 flag kept over hard reset", d, 32'h0001_0000);
        hrst_n = 1'b1; cyc(2);
        por_n = 1'b0; cyc(2);
        rd(1'b1, d); chk("R8 flag cleared by POR", d, 32'd0);
        por_n = 1'b1; cyc(2);

        // constrained random run checked against the model
        begin
            int unl = 0;
            for (int i = 0; i < 4000; i++) begin
                int r;
                @(negedge clk); #1;
                reg_wr = 1'b0; hrst_n = 1'b1;
                reg_sel = 1'($urandom_range(0, 1));
                r = int'($urandom_range(0, 199));
                if (unl > 0) begin
                    unl--;
                    pll_locked = (unl == 0);
                end else if (r < 3) begin
                    pll_locked = 1'b0;
                    unl = int'($urandom_range(1, 6));
                end
                if (r >= 3 && r < 13) begin
                    reg_wr = 1'b1; reg_sel = 1'b0;
                    reg_wdata = $urandom;
                end else if (r >= 13 && r < 17) begin
                    reg_wr = 1'b1; reg_sel = 1'b1;
                    reg_wdata = {$urandom} & 32'hFFFF_F00F;
                end else if (r >= 17 && r < 25) begin
                    reg_wr = 1'b1; reg_sel = 1'b1;
                    reg_wdata = {15'b0, 1'($urandom_range(0, 1)), 4'b0, pll_mf};
                end else if (r == 199) begin
                    hrst_n = 1'b0;
                end
            end
        end
        reg_wr = 1'b0; hrst_n = 1'b1; pll_locked = 1'b1;
        cyc(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule